// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block drives the element loop of a vector issue stage. For one vectorized instruction it walks a source element counter and a destination element counter from zero up to the vector length. Each counter follows its own predicate mask, so the block behaves as a gather from the source register vector immediately followed by a scatter into the destination vector. Every unstalled cycle it presents one source/destination element pair, together with a zero-write strobe and the index of the condition field that the element's result test must update.

Each mask is resolved when `start` is pulsed. It is taken either from integer-register bits or from one selected flag bit (optionally inverted) of each field in a vector of condition fields. A single-predicate mode steers both counters from the destination mask. Zeroing can be enabled per side. A masked-out element is then emitted with a zero-write strobe instead of being skipped, and its own condition field still gets the equal flag set. `done` marks the end of the instruction, after which the block returns to idle.

Top module: `elem_step_seq`

## Requirements
- R1: A `start` pulse sampled on a clock edge latches both resolved masks, the vector length, the mode inputs and `cr_base`, and resets both counters to element 0. The first pair is visible in the following cycle. `start` also restarts a run that is in progress.
- R2: With zeroing off, each counter skips every element whose mask bit is 0. The k-th emitted pair joins the k-th set source bit with the k-th set destination bit, and `zero_wr` stays 0.
- R3: All-ones masks take the same skip path and emit pairs (0,0), (1,1), … up to vector length minus one, one per unstalled cycle.
- R4: For each side, selecting the integer source takes element k's mask bit from bit k of that side's integer mask. Selecting the condition source takes it from `cr_fields[4*k + b]`, where b is the side's 2-bit flag select, and XORs it with the side's invert input.
- R5: When `twin` is 0, the destination mask and `dst_zero` govern both counters. The source mask inputs are ignored, and `src_idx` equals `dst_idx` on every pair.
- R6: With `dst_zero` set, a destination element whose mask bit is 0 is emitted with `zero_wr`=1. In twin mode that pair does not consume the current source element.
- R7: In twin mode with `src_zero` set, a source element whose mask bit is 0 is not skipped. It is emitted with `zero_wr`=1, and both counters advance.
- R8: On every valid pair, `cr_idx` equals (`cr_base` + `dst_idx`) modulo 128. `cr_eq` is 1 exactly on pairs that carry `zero_wr`.
- R9: As soon as either counter, after skipping, reaches the vector length, `done` is 1 with `valid` 0. After the next unstalled edge the block is idle with both low. Empty masks or a zero length emit no pairs. A length above 128 is treated as 128.
- R10: While `stall` is 1, all outputs and the internal position hold.
- R11: After reset, `valid`, `done`, `zero_wr` and `cr_eq` are 0, and so are the index outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load masks and begin a new instruction |
| stall | input | 1 | Downstream stall, holds outputs |
| vl | input | 8 | Vector length (clamped to 128) |
| twin | input | 1 | 1: separate source mask, 0: single predicate |
| src_sel_cr | input | 1 | Source mask from condition fields when 1 |
| src_cr_bit | input | 2 | Flag bit picked in each field for the source |
| src_cr_inv | input | 1 | Treat source flag as active-low |
| src_zero | input | 1 | Source zeroing enable (twin mode) |
| src_int_mask | input | 128 | Integer-register source mask |
| dst_sel_cr | input | 1 | Destination mask from condition fields when 1 |
| dst_cr_bit | input | 2 | Flag bit picked in each field for the destination |
| dst_cr_inv | input | 1 | Treat destination flag as active-low |
| dst_zero | input | 1 | Destination zeroing enable |
| dst_int_mask | input | 128 | Integer-register destination mask |
| cr_fields | input | 512 | Vector of 4-bit condition fields, field k at bits 4k+3..4k |
| cr_base | input | 7 | Base condition-field number for result tests |
| valid | output | 1 | An element pair is presented |
| zero_wr | output | 1 | The destination element receives zero |
| done | output | 1 | Instruction finished |
| src_idx | output | 7 | Source element index |
| dst_idx | output | 7 | Destination element index |
| cr_idx | output | 7 | Condition field updated by this element |
| cr_eq | output | 1 | Force the equal flag for a zeroed result |

## Verification
All-ones masks show whether the shared skip path degenerates cleanly into a plain count. Sparse, unequal twin masks with periodic stalls separate the two counters and catch a counter that follows the wrong mask or moves during a stall. Zeroing on each side in turn checks which counter is consumed on a zeroed element. Condition-field masks with a chosen flag and inversion, single-predicate runs with junk on the source mask, empty masks, zero and oversize lengths, a wrapping `cr_base` and a mid-run restart cover the remaining selection, termination and reload paths.

// File: rtl/elem_step_pkg.sv
`timescale 1ns/1ps
package elem_step_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
`timescale 1ns/1ps
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pred_mask_resolve.sv
`timescale 1ns/1ps
// Builds one side's per-element predicate from either integer bits or a
// selected flag of each condition field.
module pred_mask_resolve #(
  parameter int N = 128
) (
  input  logic           sel_cr,
  input  logic [1:0]     cr_bit,
  input  logic           cr_inv,
  input  logic [N-1:0]   int_mask,
  input  logic [4*N-1:0] cr_fields,
  output logic [N-1:0]   mask
);
  logic [N-1:0] cr_mask;

  for (genvar k = 0; k < N; k++) begin : g_field
    logic [3:0] fld;
    assign fld        = cr_fields[4*k +: 4];
    assign cr_mask[k] = fld[cr_bit] ^ cr_inv;
  end

  assign mask = sel_cr ? cr_mask : int_mask;
endmodule

// File: rtl/next_set_finder.sv
`timescale 1ns/1ps
// Returns the lowest position >= from whose mask bit is set (every position
// counts when zero_mode is set); returns N when none remains.
module next_set_finder #(
  parameter int N  = 128,
  parameter int PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask,
  input  logic          zero_mode,
  input  logic [PW-1:0] from,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = PW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if ((mask[k] || zero_mode) && (PW'(k) >= from)) pos = PW'(k);
    end
  end
endmodule

// File: rtl/elem_step_seq.sv
`timescale 1ns/1ps
module elem_step_seq #(
  parameter int MAX_VL = 128,
  parameter int IW     = $clog2(MAX_VL),
  parameter int PW     = $clog2(MAX_VL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                stall,
  input  logic [PW-1:0]       vl,
  input  logic                twin,
  input  logic                src_sel_cr,
  input  logic [1:0]          src_cr_bit,
  input  logic                src_cr_inv,
  input  logic                src_zero,
  input  logic [MAX_VL-1:0]   src_int_mask,
  input  logic                dst_sel_cr,
  input  logic [1:0]          dst_cr_bit,
  input  logic                dst_cr_inv,
  input  logic                dst_zero,
  input  logic [MAX_VL-1:0]   dst_int_mask,
  input  logic [4*MAX_VL-1:0] cr_fields,
  input  logic [IW-1:0]       cr_base,
  output logic                valid,
  output logic                zero_wr,
  output logic                done,
  output logic [IW-1:0]       src_idx,
  output logic [IW-1:0]       dst_idx,
  output logic [IW-1:0]       cr_idx,
  output logic                cr_eq
);
  import elem_step_pkg::*;

  localparam logic [PW-1:0] VL_MAX = PW'(MAX_VL);

  logic rst_sn;
  seq_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  // Mask resolution at the inputs
  logic [MAX_VL-1:0] src_res, dst_res;

  pred_mask_resolve #(.N(MAX_VL)) u_src_res (
    .sel_cr(src_sel_cr), .cr_bit(src_cr_bit), .cr_inv(src_cr_inv),
    .int_mask(src_int_mask), .cr_fields(cr_fields), .mask(src_res)
  );
  pred_mask_resolve #(.N(MAX_VL)) u_dst_res (
    .sel_cr(dst_sel_cr), .cr_bit(dst_cr_bit), .cr_inv(dst_cr_inv),
    .int_mask(dst_int_mask), .cr_fields(cr_fields), .mask(dst_res)
  );

  // State
  seq_state_e        state_q, state_d;
  logic [MAX_VL-1:0] src_m_q, dst_m_q;
  logic [PW-1:0]     vl_q, s_pos_q, s_pos_d, d_pos_q, d_pos_d;
  logic              twin_q, sz_q, dz_q;
  logic [IW-1:0]     base_q;

  // Position search after skipping
  logic [PW-1:0] s_nxt, d_nxt;

  next_set_finder #(.N(MAX_VL), .PW(PW)) u_src_find (
    .mask(src_m_q), .zero_mode(sz_q), .from(s_pos_q), .pos(s_nxt)
  );
  next_set_finder #(.N(MAX_VL), .PW(PW)) u_dst_find (
    .mask(dst_m_q), .zero_mode(dz_q), .from(d_pos_q), .pos(d_nxt)
  );

  logic running, more, s_bit, d_bit, adv_src, load_en, step_en;

  assign running = (state_q == ST_RUN);
  assign more    = running && (s_nxt < vl_q) && (d_nxt < vl_q);
  assign s_bit   = src_m_q[s_nxt[IW-1:0]];
  assign d_bit   = dst_m_q[d_nxt[IW-1:0]];
  // A zeroed destination element leaves the source in place in twin mode
  assign adv_src = twin_q ? d_bit : 1'b1;
  assign load_en = start;
  assign step_en = running && !stall;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    s_pos_d = s_pos_q;
    d_pos_d = d_pos_q;
    if (load_en) begin
      state_d = ST_RUN;
      s_pos_d = '0;
      d_pos_d = '0;
    end else if (step_en) begin
      if (more) begin
        s_pos_d = s_nxt + PW'(adv_src);
        d_pos_d = d_nxt + PW'(1);
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      s_pos_q <= '0;
      d_pos_q <= '0;
      src_m_q <= '0;
      dst_m_q <= '0;
      vl_q    <= '0;
      twin_q  <= 1'b0;
      sz_q    <= 1'b0;
      dz_q    <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      s_pos_q <= s_pos_d;
      d_pos_q <= d_pos_d;
      if (load_en) begin
        src_m_q <= twin ? src_res : dst_res;
        dst_m_q <= dst_res;
        vl_q    <= (vl > VL_MAX) ? VL_MAX : vl;
        twin_q  <= twin;
        sz_q    <= twin ? src_zero : dst_zero;
        dz_q    <= dst_zero;
        base_q  <= cr_base;
      end
    end
  end

  // Outputs
  assign valid   = more;
  assign done    = running && !more;
  assign zero_wr = more && (!s_bit || !d_bit);
  assign cr_eq   = zero_wr;
  assign src_idx = more ? s_nxt[IW-1:0] : '0;
  assign dst_idx = more ? d_nxt[IW-1:0] : '0;
  assign cr_idx  = more ? IW'(base_q + d_nxt[IW-1:0]) : '0;
endmodule

// File: rtl/elem_step_seq_chk.sv
`timescale 1ns/1ps
module elem_step_seq_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stall,
  input logic          valid,
  input logic          done,
  input logic          zero_wr,
  input logic [IW-1:0] src_idx,
  input logic [IW-1:0] dst_idx,
  input logic [IW-1:0] cr_idx,
  input logic          twin_q,
  input logic          sz_q,
  input logic          dz_q
);
  // R10
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && stall && !start) |=> (valid && $stable(src_idx) && $stable(dst_idx)
                                    && $stable(zero_wr) && $stable(cr_idx)));

  // R9
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stall && !start) |=> (!done && !valid));

  // R2
  a_r2_dst_rising: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !stall && !start) |=> (!valid || (dst_idx > $past(dst_idx))));

  // R2
  a_r2_src_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !stall && !start) |=> (!valid || (src_idx >= $past(src_idx))));

  // R5
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !twin_q) |-> (src_idx == dst_idx));

  // R2
  a_r2_no_zero_without_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sz_q && !dz_q) |-> !zero_wr);
endmodule

bind elem_step_seq elem_step_seq_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
  .valid(valid), .done(done), .zero_wr(zero_wr),
  .src_idx(src_idx), .dst_idx(dst_idx), .cr_idx(cr_idx),
  .twin_q(twin_q), .sz_q(sz_q), .dz_q(dz_q)
);

// File: tb/elem_step_seq_bench.sv
`timescale 1ns/1ps
module elem_step_seq_bench;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, stall, twin;
  logic [7:0]   vl;
  logic         src_sel_cr, src_cr_inv, src_zero;
  logic [1:0]   src_cr_bit, dst_cr_bit;
  logic         dst_sel_cr, dst_cr_inv, dst_zero;
  logic [N-1:0] src_int_mask, dst_int_mask;
  logic [4*N-1:0] cr_fields;
  logic [6:0]   cr_base;
  logic         valid, zero_wr, done, cr_eq;
  logic [6:0]   src_idx, dst_idx, cr_idx;

  always #2 clk = ~clk;

  elem_step_seq u_elem_step_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall), .vl(vl), .twin(twin),
    .src_sel_cr(src_sel_cr), .src_cr_bit(src_cr_bit), .src_cr_inv(src_cr_inv),
    .src_zero(src_zero), .src_int_mask(src_int_mask),
    .dst_sel_cr(dst_sel_cr), .dst_cr_bit(dst_cr_bit), .dst_cr_inv(dst_cr_inv),
    .dst_zero(dst_zero), .dst_int_mask(dst_int_mask),
    .cr_fields(cr_fields), .cr_base(cr_base),
    .valid(valid), .zero_wr(zero_wr), .done(done), .src_idx(src_idx),
    .dst_idx(dst_idx), .cr_idx(cr_idx), .cr_eq(cr_eq)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct { int s; int d; bit z; } pair_t;
  pair_t q[$];

  function automatic bit side_bit(bit sel_cr, logic [N-1:0] im, int b, bit inv, int k);
    if (sel_cr) return cr_fields[4*k + b] ^ inv;
    return im[k];
  endfunction

  // Behavioural model: list of expected pairs for the current inputs
  task automatic build_model();
    bit sm[N];
    bit dm[N];
    bit sz, dz;
    int len, s, d;
    q.delete();
    for (int k = 0; k < N; k++) begin
      dm[k] = side_bit(dst_sel_cr, dst_int_mask, int'(dst_cr_bit), dst_cr_inv, k);
      sm[k] = twin ? side_bit(src_sel_cr, src_int_mask, int'(src_cr_bit), src_cr_inv, k) : dm[k];
    end
    dz  = dst_zero;
    sz  = twin ? src_zero : dst_zero;
    len = (int'(vl) > N) ? N : int'(vl);
    s = 0; d = 0;
    forever begin
      while (s < len && !sm[s] && !sz) s++;
      while (d < len && !dm[d] && !dz) d++;
      if (s >= len || d >= len) break;
      q.push_back('{s: s, d: d, z: (!dm[d] || !sm[s])});
      if (!twin || dm[d]) s++;
      d++;
    end
  endtask

  task automatic fail_line(string tag, string what, int act, int exp_v);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
  endtask

  task automatic run_case(string tag, int stall_every);
    int cyc;
    bit fin;
    build_model();
    @(negedge clk);
    start = 1'b1;
    stall = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    fin = 1'b0;
    while (!fin) begin
      checks++;
      if (q.size() > 0) begin
        if (valid !== 1'b1 || done !== 1'b0)
          fail_line(tag, "valid/done", {valid, done}, 2);
        else if (src_idx !== 7'(q[0].s))
          fail_line(tag, "src_idx", int'(src_idx), q[0].s);
        else if (dst_idx !== 7'(q[0].d))
          fail_line(tag, "dst_idx", int'(dst_idx), q[0].d);
        else if (zero_wr !== q[0].z || cr_eq !== q[0].z)
          fail_line(tag, "zero_wr/cr_eq", {zero_wr, cr_eq}, {q[0].z, q[0].z});
        else if (cr_idx !== 7'(int'(cr_base) + q[0].d))
          fail_line(tag, "cr_idx", int'(cr_idx), (int'(cr_base) + q[0].d) % 128);
      end else begin
        if (valid !== 1'b0 || done !== 1'b1)
          fail_line(tag, "end valid/done", {valid, done}, 1);
      end
      stall = (stall_every != 0) && (q.size() > 0) && ((cyc % stall_every) == 1);
      if (q.size() == 0) fin = 1'b1;
      else if (!stall) void'(q.pop_front());
      @(negedge clk);
      cyc++;
    end
    checks++;
    if (valid !== 1'b0 || done !== 1'b0)
      fail_line(tag, "idle after done", {valid, done}, 0);
  endtask

  task automatic defaults();
    twin = 1'b1; vl = 8'd16;
    src_sel_cr = 1'b0; src_cr_bit = 2'd0; src_cr_inv = 1'b0; src_zero = 1'b0;
    dst_sel_cr = 1'b0; dst_cr_bit = 2'd0; dst_cr_inv = 1'b0; dst_zero = 1'b0;
    src_int_mask = '1; dst_int_mask = '1; cr_base = 7'd0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stall = 1'b0;
    for (int i = 0; i < 4*N; i++) cr_fields[i] = ((i * 7 + 3) % 5) < 2;
    defaults();
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (valid !== 1'b0 || done !== 1'b0 || zero_wr !== 1'b0 || cr_eq !== 1'b0 ||
        src_idx !== 7'd0 || dst_idx !== 7'd0 || cr_idx !== 7'd0)
      fail_line("R11", "reset outputs", {valid, done, zero_wr, cr_eq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: all-ones masks
    defaults(); vl = 8'd8;
    run_case("R3", 0);

    // R2 and R10: sparse twin masks with stalls
    defaults();
    src_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_B6D1;
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_5A3C;
    run_case("R2", 0);
    run_case("R10", 3);

    // R5: single predicate, source mask is junk and must be ignored
    defaults(); twin = 1'b0;
    src_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_0001;
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_5A5A;
    src_zero = 1'b1;
    run_case("R5", 2);

    // R6 and R8: destination zeroing, wrapping base
    defaults(); dst_zero = 1'b1; cr_base = 7'd125;
    src_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_0F0F;
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_3333;
    run_case("R6", 0);
    run_case("R8", 4);

    // R5 with zeroing in single mode
    defaults(); twin = 1'b0; dst_zero = 1'b1; vl = 8'd12;
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_0925;
    run_case("R5", 0);

    // R7: source zeroing
    defaults(); src_zero = 1'b1;
    src_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_00F5;
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_EEEE;
    run_case("R7", 0);

    // R4: condition-field masks, chosen flag and inversion
    defaults(); vl = 8'd40;
    src_sel_cr = 1'b1; src_cr_bit = 2'd2; src_cr_inv = 1'b1;
    dst_sel_cr = 1'b1; dst_cr_bit = 2'd1; dst_cr_inv = 1'b0;
    run_case("R4", 5);
    dst_sel_cr = 1'b0; dst_int_mask = 128'h0000_0000_0000_0000_FFFF_0000_FFFF_00FF;
    src_cr_bit = 2'd3; src_cr_inv = 1'b0;
    run_case("R4", 0);

    // R9: empty masks, zero length, oversize length
    defaults(); vl = 8'd10; src_int_mask = '0; dst_int_mask = '0;
    run_case("R9", 0);
    defaults(); vl = 8'd0;
    run_case("R9", 0);
    defaults(); vl = 8'd200;
    run_case("R9", 7);

    // R1: restart while a run is in progress
    defaults(); vl = 8'd100;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    dst_int_mask = 128'h0000_0000_0000_0000_0000_0000_0000_A0A0;
    vl = 8'd16;
    run_case("R1", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule